// File: doc/BRIEF.md
# Configurable Asynchronous Character Framer

This block holds the serial framing logic for one asynchronous channel. A transmitter takes a byte over a valid/ready handshake and sends it as a start bit, then 5 to 8 data bits with the least significant first, then an optional parity bit and a stop period. A receiver watches the incoming line, confirms a start bit near its middle and samples each following bit at mid-bit. It returns the assembled byte together with parity-error, framing-error and break flags.

Both halves run from a single-cycle sample enable that pulses at sixteen times the bit rate. The divider that produces this enable sits outside the block, and so do any queues. A six-bit configuration word sets the word length, the stop period and the parity mode. The transmitter captures this word when it accepts a byte. The receiver captures it when it detects a start edge.

Top module: `async_framer`

## Requirements
- R1: After reset `txd` is high, `tx_ready` is high and `rx_valid` is low; whenever `tx_ready` is high, `txd` is high.
- R2: A byte is taken at a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low until the whole frame, including its stop period, has been sent.
- R3: The transmitted frame is a low start bit followed by the data bits, least significant first. Each bit lasts 16 sample enables. `line_cfg[1:0]` = 00, 01, 10, 11 selects 5, 6, 7 or 8 data bits.
- R4: `line_cfg[3]`=1 adds a parity bit after the data. With `line_cfg[5]`=0, the parity bit is chosen so that the count of ones over the data and parity is even when `line_cfg[4]`=1 and odd when `line_cfg[4]`=0. With `line_cfg[5]`=1, the parity bit is the inverse of `line_cfg[4]`.
- R5: The stop period is high. With `line_cfg[2]`=0 it lasts 16 sample enables. With `line_cfg[2]`=1 it lasts 24 for a 5-bit word and 32 for longer words. `tx_ready` rises on the enable that ends the stop period.
- R6: While a frame is in progress, `txd` changes only at edges where `tick16` is high.
- R7: A low line detected on a sample enable is taken as a start bit only if the line is still low 8 enables later. Otherwise it is ignored as a glitch and produces no `rx_valid`.
- R8: For each accepted start bit, `rx_valid` pulses for one cycle, at the middle of the first stop bit. `rx_data` then holds the received bits in their positions, and every bit above the word length is zero.
- R9: `rx_perr` is set when parity is enabled and the received parity bit differs from the value R4 gives for the received data.
- R10: `rx_ferr` is set when the first stop bit is sampled low.
- R11: `rx_brk` is set when every sampled data bit, the parity bit (if enabled) and the stop bit are low. After a low stop bit, the receiver waits for the line to return high before it looks for another start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sample enable at 16 times the bit rate |
| line_cfg | input | 6 | [1:0] word length, [2] long stop, [3] parity on, [4] even sense, [5] forced parity |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter idle and able to take a byte |
| txd | output | 1 | Serial output, high when idle |
| rxd | input | 1 | Serial input, asynchronous |
| rx_data | output | 8 | Received byte, zero above the word length |
| rx_valid | output | 1 | One-cycle pulse, received character ready |
| rx_perr | output | 1 | Parity mismatch on the last character |
| rx_ferr | output | 1 | Low stop bit on the last character |
| rx_brk | output | 1 | Whole character low, break condition |

## Verification
The assertions check every cycle that the idle line is high while the transmitter is ready, that an accepted byte drops `tx_ready` and drives the start bit, and that `txd` changes only on sample enables. They also check that `rx_valid` is a single-cycle pulse and that a break always arrives with a framing error and zero data. Bit order, parity values for every sense and forced mode, stop-period length and receiver sampling can only be shown by the bench. It sends frames bit by bit against the sample enable, measures the position of each transmitted bit and compares the received byte and flags with values it computes itself.

// File: rtl/afr_pkg.sv
package afr_pkg;

    typedef struct packed {
        logic force_par;   // [5]
        logic even_sel;    // [4]
        logic par_en;      // [3]
    } par_cfg_t;

    typedef struct packed {
        par_cfg_t   par;       // [5:3]
        logic       long_stop; // [2]
        logic [1:0] wsel;      // [1:0]
    } line_cfg_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_WAITHI
    } fr_state_t;

    function automatic logic [3:0] word_bits(input logic [1:0] wsel);
        return 4'd5 + {2'b00, wsel};
    endfunction

    function automatic logic [7:0] word_mask(input logic [1:0] wsel);
        return 8'hFF >> (2'd3 - wsel);
    endfunction

    // Parity bit for a word under the given parity settings
    function automatic logic par_of(input logic [7:0] d, input logic [1:0] wsel,
                                    input par_cfg_t pc);
        logic ones;
        ones = ^(d & word_mask(wsel));
        if (pc.force_par) return ~pc.even_sel;
        return pc.even_sel ? ones : ~ones;
    endfunction

    // Stop period length in sample enables
    function automatic int stop_len(input line_cfg_t c, input int ovs);
        if (!c.long_stop)     return ovs;
        if (c.wsel == 2'b00)  return ovs + ovs / 2;
        return 2 * ovs;
    endfunction

endpackage

// File: rtl/afr_sync.sv
module afr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/afr_tx.sv
module afr_tx
    import afr_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  line_cfg_t cfg_i,
    input  logic [7:0] data_i,
    input  logic      valid_i,
    output logic      ready_o,
    output logic      txd_o
);
    localparam int CW = $clog2(2 * OVS) + 1;

    fr_state_t    st;
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic [2:0]   bidx;
    logic [2:0]   last_idx;
    logic [7:0]   shreg;
    logic [7:0]   data_q;
    line_cfg_t    cfg_q;
    logic         txd_q;
    logic         bit_end;

    always_comb begin
        limit    = (st == S_STOP) ? CW'(stop_len(cfg_q, OVS)) : CW'(OVS);
        last_idx = 3'(word_bits(cfg_q.wsel) - 4'd1);
        bit_end  = tick && (cnt == limit - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cnt    <= '0;
            bidx   <= '0;
            shreg  <= '0;
            data_q <= '0;
            cfg_q  <= '0;
            txd_q  <= 1'b1;
        end else begin
            case (st)
                S_IDLE: begin
                    if (valid_i) begin
                        st     <= S_START;
                        shreg  <= data_i;
                        data_q <= data_i;
                        cfg_q  <= cfg_i;
                        cnt    <= '0;
                        bidx   <= '0;
                        txd_q  <= 1'b0;
                    end
                end
                default: begin
                    if (tick) begin
                        if (bit_end) begin
                            cnt <= '0;
                            case (st)
                                S_START: begin
                                    st    <= S_DATA;
                                    txd_q <= shreg[0];
                                    shreg <= {1'b0, shreg[7:1]};
                                end
                                S_DATA: begin
                                    if (bidx == last_idx) begin
                                        if (cfg_q.par.par_en) begin
                                            st    <= S_PAR;
                                            txd_q <= par_of(data_q, cfg_q.wsel, cfg_q.par);
                                        end else begin
                                            st    <= S_STOP;
                                            txd_q <= 1'b1;
                                        end
                                    end else begin
                                        bidx  <= bidx + 3'd1;
                                        txd_q <= shreg[0];
                                        shreg <= {1'b0, shreg[7:1]};
                                    end
                                end
                                S_PAR: begin
                                    st    <= S_STOP;
                                    txd_q <= 1'b1;
                                end
                                default: begin
                                    st    <= S_IDLE;
                                    txd_q <= 1'b1;
                                end
                            endcase
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign ready_o = (st == S_IDLE);
    assign txd_o   = txd_q;
endmodule

// File: rtl/afr_rx.sv
module afr_rx
    import afr_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd_i,
    input  logic [1:0] wsel_i,
    input  par_cfg_t   par_i,
    output logic [7:0] data_o,
    output logic       valid_o,
    output logic       perr_o,
    output logic       ferr_o,
    output logic       brk_o
);
    localparam int CW   = $clog2(OVS) + 1;
    localparam int HALF = OVS / 2;

    fr_state_t     st;
    logic [CW-1:0] cnt;
    logic [2:0]    bidx;
    logic [2:0]    last_idx;
    logic [7:0]    dreg;
    logic [1:0]    wsel_q;
    par_cfg_t      par_q;
    logic          pbit;
    logic          zeros;
    logic          mid;

    always_comb begin
        last_idx = 3'(word_bits(wsel_q) - 4'd1);
        mid      = tick && (cnt == CW'(OVS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            cnt     <= '0;
            bidx    <= '0;
            dreg    <= '0;
            wsel_q  <= '0;
            par_q   <= '0;
            pbit    <= 1'b0;
            zeros   <= 1'b0;
            data_o  <= '0;
            valid_o <= 1'b0;
            perr_o  <= 1'b0;
            ferr_o  <= 1'b0;
            brk_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (tick && !rxd_i) begin
                        st     <= S_START;
                        cnt    <= '0;
                        bidx   <= '0;
                        dreg   <= '0;
                        zeros  <= 1'b1;
                        wsel_q <= wsel_i;
                        par_q  <= par_i;
                    end
                end
                S_START: begin
                    if (tick) begin
                        if (cnt == CW'(HALF - 1)) begin
                            cnt <= '0;
                            st  <= rxd_i ? S_IDLE : S_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                S_DATA: begin
                    if (mid) begin
                        cnt        <= '0;
                        dreg[bidx] <= rxd_i;
                        if (rxd_i) zeros <= 1'b0;
                        if (bidx == last_idx) st <= par_q.par_en ? S_PAR : S_STOP;
                        else                  bidx <= bidx + 3'd1;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_PAR: begin
                    if (mid) begin
                        cnt  <= '0;
                        pbit <= rxd_i;
                        if (rxd_i) zeros <= 1'b0;
                        st   <= S_STOP;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_STOP: begin
                    if (mid) begin
                        cnt     <= '0;
                        valid_o <= 1'b1;
                        data_o  <= dreg;
                        ferr_o  <= !rxd_i;
                        perr_o  <= par_q.par_en && (pbit != par_of(dreg, wsel_q, par_q));
                        brk_o   <= zeros && !rxd_i;
                        st      <= rxd_i ? S_IDLE : S_WAITHI;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (rxd_i) st <= S_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/async_framer.sv
module async_framer
    import afr_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int SYNC_LEN  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic [5:0] line_cfg,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       txd,
    input  logic       rxd,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_brk
);
    line_cfg_t cfg;
    logic      rxd_s;

    assign cfg = line_cfg_t'(line_cfg);

    afr_tx #(.OVS(OVS)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .cfg_i   (cfg),
        .data_i  (tx_data),
        .valid_i (tx_valid),
        .ready_o (tx_ready),
        .txd_o   (txd)
    );

    afr_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (rxd),
        .q_o (rxd_s)
    );

    afr_rx #(.OVS(OVS)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .rxd_i   (rxd_s),
        .wsel_i  (cfg.wsel),
        .par_i   (cfg.par),
        .data_o  (rx_data),
        .valid_o (rx_valid),
        .perr_o  (rx_perr),
        .ferr_o  (rx_ferr),
        .brk_o   (rx_brk)
    );
endmodule

// File: rtl/async_framer_chk.sv
module async_framer_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick16,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       txd,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_ferr,
    input logic       rx_brk
);
    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> txd);

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !tx_ready);

    p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !txd);

    p_tick_only_r6: assert property (@(posedge clk) disable iff (rst)
        (!tick16 && !tx_ready) |=> $stable(txd));

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_break_form_r11: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_brk) |-> (rx_ferr && rx_data == 8'h00));
endmodule

bind async_framer async_framer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick16   (tick16),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .txd      (txd),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_ferr  (rx_ferr),
    .rx_brk   (rx_brk)
);

// File: tb/async_framer_test.sv
module async_framer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic [5:0] line_cfg = '0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       txd;
    logic       rxd = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_perr;
    logic       rx_ferr;
    logic       rx_brk;

    int checks = 0;
    int errors = 0;
    int tick_count = 0;
    int div = 0;
    int got_n = 0;
    logic [7:0] g_data;
    logic g_perr, g_ferr, g_brk;

    async_framer uut (
        .clk(clk), .rst(rst), .tick16(tick16), .line_cfg(line_cfg),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk)
    );

    always #2 clk = ~clk;

    // sample enable every third cycle, driven away from the active edge
    always @(negedge clk) begin
        if (div == 2) begin div = 0; tick16 = 1'b1; end
        else begin div = div + 1; tick16 = 1'b0; end
    end

    always @(posedge clk) if (!rst && tick16) tick_count <= tick_count + 1;

    always @(negedge clk) begin
        if (rx_valid) begin
            got_n  = got_n + 1;
            g_data = rx_data;
            g_perr = rx_perr;
            g_ferr = rx_ferr;
            g_brk  = rx_brk;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wbits(input logic [5:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input logic [5:0] c);
        logic ones = 1'b0;
        if (c[5]) return ~c[4];
        for (int i = 0; i < wbits(c); i++) ones ^= d[i];
        return c[4] ? ones : ~ones;
    endfunction

    function automatic int stop_t(input logic [5:0] c);
        if (!c[2]) return 16;
        if (c[1:0] == 2'b00) return 24;
        return 32;
    endfunction

    task automatic wait_to(input int n);
        while (tick_count < n) @(negedge clk);
    endtask

    task automatic tx_frame(input logic [7:0] d, input logic [5:0] c);
        int t0, nb, w, total;
        logic e;
        w  = wbits(c);
        nb = 1 + w + int'(c[3]);
        @(negedge clk);
        chk(tx_ready === 1'b1, "R2 ready before offer", int'(tx_ready), 1);
        line_cfg = c; tx_data = d; tx_valid = 1'b1;
        @(posedge clk); #1;
        t0 = tick_count;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready === 1'b0, "R2 busy after accept", int'(tx_ready), 0);
        for (int k = 0; k < nb; k++) begin
            if (k == 0)      e = 1'b0;
            else if (k <= w) e = d[k-1];
            else             e = exp_par(d, c);
            wait_to(t0 + 16 * k + 8);
            chk(txd === e, (k == 0) ? "R3 start" : (k <= w) ? "R3 data bit" : "R4 parity",
                int'(txd), int'(e));
        end
        wait_to(t0 + 16 * nb + 8);
        chk(txd === 1'b1, "R5 stop high", int'(txd), 1);
        total = 16 * nb + stop_t(c);
        wait_to(t0 + total - 1);
        chk(tx_ready === 1'b0, "R5 stop not short", int'(tx_ready), 0);
        wait_to(t0 + total);
        chk(tx_ready === 1'b1, "R5 stop end", int'(tx_ready), 1);
    endtask

    task automatic drive_bit(input logic v);
        int t;
        rxd = v;
        t = tick_count;
        wait_to(t + 16);
    endtask

    task automatic rx_frame(input logic [7:0] d, input logic [5:0] c,
                            input logic flip, input logic stopv);
        int n0, w;
        logic pb;
        logic [7:0] m;
        w  = wbits(c);
        m  = 8'hFF >> (8 - w);
        pb = exp_par(d, c) ^ flip;
        n0 = got_n;
        @(negedge clk);
        line_cfg = c;
        drive_bit(1'b0);
        for (int i = 0; i < w; i++) drive_bit(d[i]);
        if (c[3]) drive_bit(pb);
        drive_bit(stopv);
        drive_bit(1'b1);
        drive_bit(1'b1);
        chk(got_n == n0 + 1, "R8 one valid", got_n - n0, 1);
        chk(g_data === (d & m), "R8 data", int'(g_data), int'(d & m));
        chk(g_perr === (c[3] & flip), "R9 parity flag", int'(g_perr), int'(c[3] & flip));
        chk(g_ferr === !stopv, "R10 framing flag", int'(g_ferr), int'(!stopv));
        chk(g_brk === (!stopv && (d & m) == 0 && (!c[3] || pb == 1'b0)),
            "R11 break flag", int'(g_brk),
            int'(!stopv && (d & m) == 0 && (!c[3] || pb == 1'b0)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n0, t;
        void'($urandom(32'h1d2c_3b4a));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1, "R1 txd idle", int'(txd), 1);
        chk(tx_ready === 1'b1, "R1 ready idle", int'(tx_ready), 1);
        chk(rx_valid === 1'b0, "R1 no valid", int'(rx_valid), 0);

        // directed transmit cases
        tx_frame(8'hA5, 6'b000011);   // 8 bits, no parity, 1 stop
        tx_frame(8'h3B, 6'b011011);   // even parity
        tx_frame(8'h2C, 6'b001010);   // odd parity, 7 bits
        tx_frame(8'h15, 6'b000100);   // 5 bits, 1.5 stop
        tx_frame(8'hC3, 6'b000111);   // 8 bits, 2 stop
        tx_frame(8'h2A, 6'b101001);   // forced parity, sense 0 -> 1
        tx_frame(8'h1F, 6'b111000);   // forced parity, sense 1 -> 0
        for (int i = 0; i < 10; i++)
            tx_frame(8'($urandom), 6'($urandom));

        // directed receive cases
        rx_frame(8'h5A, 6'b000011, 1'b0, 1'b1);
        rx_frame(8'hFF, 6'b000000, 1'b0, 1'b1);   // masked to 5 bits
        rx_frame(8'h4D, 6'b011010, 1'b1, 1'b1);   // parity error
        rx_frame(8'h33, 6'b101011, 1'b1, 1'b1);   // forced parity error
        rx_frame(8'h81, 6'b000011, 1'b0, 1'b0);   // framing error
        rx_frame(8'h00, 6'b011011, 1'b0, 1'b0);   // break, parity bit low

        // glitch shorter than half a bit
        n0 = got_n;
        @(negedge clk);
        rxd = 1'b0;
        t = tick_count;
        wait_to(t + 3);
        rxd = 1'b1;
        wait_to(t + 60);
        chk(got_n == n0, "R7 glitch ignored", got_n - n0, 0);

        for (int i = 0; i < 10; i++)
            rx_frame(8'($urandom), 6'($urandom), 1'($urandom), ($urandom % 4) != 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule